// File: doc/BRIEF.md
# DTMF Delayed Steering Guard Timer

This block sits after a dual-tone recogniser. Its input is a raw early-steering level that is high whenever a tone pair is currently recognised. It turns that level into a delayed steering output that marks a validated digit. The output rises only after the input has stayed high for a tone-present guard time. Once high, it falls only after the input has stayed low for a tone-absent guard time. Brief tone bursts are therefore rejected, and brief dropouts inside a digit are bridged. A one-cycle pulse also marks the start of each new digit.

Time is measured in ticks of a divider driven by the system clock. By default the clock is 4.194304 MHz and the tick period is 1 ms. Both guard times default to 30 ms. That value sits between the 20 ms reject limit and the 40 ms accept limit for tone duration and for pause length. The early-steering input is retimed through two flops. A powerdown input returns the block to idle and holds the output low.

A four-state machine does the work. IDLE waits for tone. QUALIFY counts the present guard. VALID holds the output high while tone is present. RELEASE counts the absent guard. The transitions are:
- IDLE→QUALIFY when tone appears.
- QUALIFY→IDLE when tone is lost before the guard completes.
- QUALIFY→VALID when the present count completes.
- VALID→RELEASE when tone drops.
- RELEASE→VALID when tone returns before the absent count completes.
- RELEASE→IDLE when the absent count completes.
- Any state→IDLE when powerdown is asserted.

Top module: `dtmf_guard_timer`

## Requirements
- R1: After synchronous reset, `dstd_out` and `digit_pulse` are both 0.
- R2: A tone whose retimed early steering stays high for no more than (PRESENT_MS-1) tick periods never raises `dstd_out`.
- R3: A tone held high for at least PRESENT_MS tick periods plus the three-cycle pipeline always raises `dstd_out`. The rise happens only on the move from QUALIFY to VALID.
- R4: `digit_pulse` is high for exactly one cycle, in the same cycle that `dstd_out` rises, and at no other time.
- R5: While `dstd_out` is high, a dropout of no more than (ABSENT_MS-1) tick periods leaves `dstd_out` high and produces no new pulse.
- R6: A pause of at least ABSENT_MS tick periods plus the pipeline lowers `dstd_out`. A later qualifying tone is then recognised as a new digit. `dstd_out` falls only after early steering was low or powerdown was high.
- R7: A loss of tone during QUALIFY clears the present count. Two short bursts separated by a gap therefore do not add up.
- R8: Tone returning during RELEASE clears the absent count. Two short dropouts separated by tone therefore do not add up.
- R9: While `pwdn` is high, `dstd_out` is 0 from the cycle after `pwdn` is first sampled. The machine returns to IDLE, so after `pwdn` falls a held tone must qualify again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4.194304 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| pwdn | input | 1 | Powerdown, active high, synchronous |
| est_in | input | 1 | Raw early steering, high while a tone pair is recognised |
| dstd_out | output | 1 | Delayed steering, high while a validated digit is present |
| digit_pulse | output | 1 | One-cycle pulse on each rise of `dstd_out` |

## Verification
The bench drives early steering with several patterns:
- Single bursts on each side of the present guard, which separate rejection from acceptance.
- Split bursts whose total exceeds the guard, which show whether QUALIFY clears its count.
- Short single and double dropouts inside a valid digit, which show whether RELEASE bridges the gap and clears its count when tone returns.
- A long pause followed by a fresh tone, which shows release and recognition of the next digit.
- Powerdown asserted during a held tone, which shows the forced low output and the need to qualify again afterwards.

A scoreboard matches every `digit_pulse` against the burst expected to produce it. This catches spurious, missing and late digits.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_QUALIFY = 2'd1,
        S_VALID   = 2'd2,
        S_RELEASE = 2'd3
    } guard_state_t;
endpackage

// File: rtl/dg_sync2.sv
module dg_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dg_tick_gen.sv
module dg_tick_gen #(
    parameter int DIV = 4194
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);

    // Divider count never leaves its range
    p_div_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/dg_guard_fsm.sv
module dg_guard_fsm
    import dtmf_guard_pkg::*;
#(
    parameter int PRESENT_TICKS = 30,
    parameter int ABSENT_TICKS  = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic pwdn,
    input  logic est,
    input  logic tick,
    output logic dstd,
    output logic pulse
);
    localparam int MAXT = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] P_LAST = CW'(PRESENT_TICKS - 1);
    localparam logic [CW-1:0] A_LAST = CW'(ABSENT_TICKS - 1);

    guard_state_t state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (pwdn) begin
            nxt     = S_IDLE;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    cnt_nxt = '0;
                    if (est) nxt = S_QUALIFY;
                end
                S_QUALIFY: begin
                    if (!est) begin
                        nxt     = S_IDLE;
                        cnt_nxt = '0;
                    end else if (tick) begin
                        if (cnt == P_LAST) begin
                            nxt     = S_VALID;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + CW'(1);
                        end
                    end
                end
                S_VALID: begin
                    cnt_nxt = '0;
                    if (!est) nxt = S_RELEASE;
                end
                S_RELEASE: begin
                    if (est) begin
                        nxt     = S_VALID;
                        cnt_nxt = '0;
                    end else if (tick) begin
                        if (cnt == A_LAST) begin
                            nxt     = S_IDLE;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dstd  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            dstd  <= (nxt == S_VALID) || (nxt == S_RELEASE);
            pulse <= (state == S_QUALIFY) && (nxt == S_VALID);
        end
    end

    p_rise_from_qualify_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dstd) |-> (state == S_VALID) && ($past(state) == S_QUALIFY));

    p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        pulse |-> dstd && !$past(dstd));

    p_fall_needs_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(dstd) |-> $past(pwdn) || !$past(est));

    p_pwdn_low_r9: assert property (@(posedge clk) disable iff (rst)
        pwdn |=> !dstd);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAXT - 1));
endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
    parameter int CLK_HZ     = 4194304,
    parameter int TICK_HZ    = 1000,
    parameter int PRESENT_MS = 30,
    parameter int ABSENT_MS  = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic pwdn,
    input  logic est_in,
    output logic dstd_out,
    output logic digit_pulse
);
    localparam int TICK_DIV = CLK_HZ / TICK_HZ;

    logic est_s;
    logic tick;

    dg_sync2 #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (est_in),
        .q   (est_s)
    );

    dg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dg_guard_fsm #(
        .PRESENT_TICKS (PRESENT_MS),
        .ABSENT_TICKS  (ABSENT_MS)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .pwdn  (pwdn),
        .est   (est_s),
        .tick  (tick),
        .dstd  (dstd_out),
        .pulse (digit_pulse)
    );
endmodule

// File: tb/dtmf_guard_timer_bench.sv
module dtmf_guard_timer_bench;
    // 4 cycles per tick, 6-tick guards: reject <= 20 cycles, accept >= 24 cycles
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwdn = 1'b0;
    logic est_in = 1'b0;
    logic dstd_out, digit_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int rises   = 0;
    int falls   = 0;
    int cur_burst = 0;
    int exp_q[$];
    logic dstd_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dtmf_guard_timer #(
        .CLK_HZ(4000), .TICK_HZ(1000), .PRESENT_MS(6), .ABSENT_MS(6)
    ) u_dtmf_guard_timer (
        .clk(clk), .rst(rst), .pwdn(pwdn), .est_in(est_in),
        .dstd_out(dstd_out), .digit_pulse(digit_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (dstd_out && !dstd_prev) rises++;
            if (!dstd_out && dstd_prev) falls++;
            if (digit_pulse != (dstd_out && !dstd_prev)) begin
                check("R4 pulse-aligned-with-rise", int'(digit_pulse), int'(dstd_out && !dstd_prev));
            end
            if (digit_pulse) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected digit, burst", cur_burst, -1);
                end else begin
                    check("R4 digit burst id", cur_burst, exp_q.pop_front());
                end
            end
            dstd_prev = dstd_out;
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        cyc(5);
        check("R1 dstd after reset", int'(dstd_out), 0);
        check("R1 pulse after reset", int'(digit_pulse), 0);
        rst = 1'b0;
        cyc(10);

        // R2: short tone rejected
        cur_burst = 1;
        est_in = 1'b1; cyc(16);
        est_in = 1'b0; cyc(30);
        check("R2 short tone rises", rises, 0);

        // R3: long tone accepted
        cur_burst = 2; exp_q.push_back(2);
        est_in = 1'b1; cyc(38);
        check("R3 long tone dstd", int'(dstd_out), 1);

        // R5: short dropout bridged
        est_in = 1'b0; cyc(12);
        est_in = 1'b1; cyc(10);
        check("R5 dstd after dropout", int'(dstd_out), 1);
        check("R5 falls after dropout", falls, 0);

        // R8: two dropouts with tone between do not add
        est_in = 1'b0; cyc(16);
        est_in = 1'b1; cyc(4);
        est_in = 1'b0; cyc(16);
        est_in = 1'b1; cyc(10);
        check("R8 dstd after split dropouts", int'(dstd_out), 1);
        check("R8 falls after split dropouts", falls, 0);

        // R6: long pause releases
        est_in = 1'b0; cyc(40);
        check("R6 dstd after pause", int'(dstd_out), 0);
        check("R6 falls after pause", falls, 1);

        // R7: split bursts do not add
        cur_burst = 3;
        est_in = 1'b1; cyc(16);
        est_in = 1'b0; cyc(3);
        est_in = 1'b1; cyc(16);
        est_in = 1'b0; cyc(30);
        check("R7 split bursts rises", rises, 1);

        // R6: next digit after pause
        cur_burst = 4; exp_q.push_back(4);
        est_in = 1'b1; cyc(38);
        check("R6 next digit dstd", int'(dstd_out), 1);

        // R9: powerdown forces low and requires requalification
        pwdn = 1'b1; cyc(2);
        check("R9 dstd in powerdown", int'(dstd_out), 0);
        cyc(60);
        check("R9 dstd held in powerdown", int'(dstd_out), 0);
        cur_burst = 5; exp_q.push_back(5);
        pwdn = 1'b0; cyc(2);
        check("R9 no immediate reassert", int'(dstd_out), 0);
        cyc(36);
        check("R9 requalified dstd", int'(dstd_out), 1);
        est_in = 1'b0; cyc(40);
        check("R6 final release", int'(dstd_out), 0);

        check("R4 missing digits", exp_q.size(), 0);
        check("R3 total rises", rises, 3);
        check("R6 total falls", falls, 3);
        done = 1'b1;
        finish_run();
    end
endmodule